// File: doc/BRIEF.md
# Two-Port GPIO Bank with Transition Interrupt

This block holds two general-purpose pin ports, one 8 bits and one 7 bits wide, behind a small indexed register bus. Each pin can be an input or an output. A per-pin inversion bit applies to both directions. Each output pin drives either a steady level or a fixed-length pulse. Each port also keeps a snapshot of its pin levels taken right after power-on reset, and again during an external reset when software allows it.

Inputs pass through a two-flop synchronizer. Any change of level on a pin configured as input sets a sticky status bit, and reading the status register clears it. Enabled status bits combine into one interrupt. The interrupt can drive either the top pin of port 1 or the top pin of port 2, in level or pulse form, with a selectable idle level. An external reset input returns a port's configuration to its defaults only when software has allowed it for that port. Power-on reset always does so.

Register map. Port 1 sits at base 0x00 and port 2 at base 0x08. The offset within a base selects:
- 0: direction
- 1: output data
- 2: inversion
- 3: output style
- 4: input data (read only)
- 5: snapshot (read only)
- 6: status (read clears)
- 7: interrupt enable

The mode register is at 0x10. Its bits are:
- bit 7: interrupt pin on
- bit 6: interrupt on port 2 (1) or port 1 (0)
- bit 5: pulse interrupt
- bit 4: interrupt idles high
- bit 3: port 2 follows external reset
- bit 2: port 1 follows external reset
- bit 1: port 2 snapshot on external reset
- bit 0: port 1 snapshot on external reset

Top module: `gpio_xint_bank`

## Requirements
- R1: A direction bit of 1 makes its pin an input (output enable low) and 0 makes it an output; after power-on reset port 1 direction reads 0xFF and port 2 reads 0x7F.
- R2: An inversion bit of 1 inverts both the read input value and the driven output value; after power-on reset port 1 inversion reads 0xF0 and port 2 reads 0x70.
- R3: With style bit 0 a pin drives its output data bit XOR its inversion bit from the cycle after the write, and the output data register reads back the written value.
- R4: With style bit 1, writing 1 to the output data bit drives the pin to the inverse of its inversion bit for exactly 16 clocks starting the cycle after the write; the pin then returns to its inversion bit value.
- R5: The input data register reads the pin level XOR the inversion bit, with two clocks of synchronizer latency.
- R6: The snapshot register captures the raw pin levels on the first clock after power-on reset. It captures again on each clock of external reset only if mode bit 0 (port 1) or bit 1 (port 2) is set.
- R7: A level change on an input pin sets its status bit from the third clock after the change. A status read returns the bits and clears them, but a change detected in the same clock as the read stays set. Output pins never set status.
- R8: With mode bit 7 set, the selected pin (port 1 bit 7 when mode bit 6 is 0, port 2 bit 6 when 1) is forced to output. In level mode it drives the active level (the inverse of mode bit 4) while any enabled status bit is set, and returns to idle on the clock after the status is read clear.
- R9: In pulse mode (mode bit 5) the interrupt pin drives the active level for 16 clocks when the pending condition first rises. No further pulse occurs until the status has been cleared and a new enabled change is seen.
- R10: The status bit of the pin that carries the interrupt always reads 0 and never contributes to the interrupt.
- R11: While the external reset input is low, a port whose mode bit (2 for port 1, 3 for port 2) is set returns its direction, output, inversion, style, status and enable registers to their defaults. Otherwise the port keeps them. The mode register changes only by write or power-on reset.
- R12: Index 0x20 reads 0x60, index 0x21 reads 0x13, and every unused index reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| ext_rst_n | input | 1 | External reset request, sampled on the clock, active low |
| reg_idx | input | 8 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one clock per write |
| reg_rd | input | 1 | Read strobe; marks a read that has side effects |
| reg_rdata | output | 8 | Read data for reg_idx, combinational |
| p1_in | input | 8 | Port 1 pin levels |
| p1_out | output | 8 | Port 1 driven values |
| p1_oe | output | 8 | Port 1 output enables |
| p2_in | input | 7 | Port 2 pin levels |
| p2_out | output | 7 | Port 2 driven values |
| p2_oe | output | 7 | Port 2 output enables |

## Verification
A wrong direction, inversion or style bit shows on the pin outputs in the very next clock, and a stuck pulse counter shows as a pulse that is too long or too short within 17 clocks. Faults in the synchronizer or edge detection show as status bits that are missing, extra or late by one clock three clocks after a pin change. A lost clear-on-read race shows at the next status read. A wrong interrupt-rearm flag shows as a missing or duplicated interrupt pulse within about 20 clocks of the second pin change. The behavioural model is compared with every output on every clock, so each of these faults is reported in the cycle it first becomes visible.

// File: rtl/gpio_xint_pkg.sv
package gpio_xint_pkg;

  localparam int REG_W = 8;

  typedef enum logic [2:0] {
    F_DIR = 3'd0,
    F_OUT = 3'd1,
    F_POL = 3'd2,
    F_STY = 3'd3,
    F_IN  = 3'd4,
    F_LAT = 3'd5,
    F_STS = 3'd6,
    F_IEN = 3'd7
  } field_e;

  localparam logic [7:0] IDX_P1    = 8'h00;
  localparam logic [7:0] IDX_P2    = 8'h08;
  localparam logic [7:0] IDX_MODE  = 8'h10;
  localparam logic [7:0] IDX_ID_HI = 8'h20;
  localparam logic [7:0] IDX_ID_LO = 8'h21;
  localparam logic [7:0] ID_HI_VAL = 8'h60;
  localparam logic [7:0] ID_LO_VAL = 8'h13;

  typedef struct packed {
    logic int_on;
    logic int_alt;
    logic int_pulse;
    logic int_idle_hi;
    logic p2_xrst;
    logic p1_xrst;
    logic p2_xlat;
    logic p1_xlat;
  } mode_t;

endpackage

// File: rtl/gpio_xint_pulse.sv
module gpio_xint_pulse #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  output logic active
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                cnt_d = '0;
    else if (start)         cnt_d = CW'(LEN);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/gpio_xint_port.sv
module gpio_xint_port
  import gpio_xint_pkg::*;
#(
  parameter int           W       = 8,
  parameter logic [7:0]   BASE    = 8'h00,
  parameter logic [W-1:0] DIR_RST = '1,
  parameter logic [W-1:0] POL_RST = '0,
  parameter int           LEN     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ext_clr,
  input  logic         cap_now,
  input  logic         armed,
  input  logic [7:0]   idx,
  input  logic [7:0]   wdata,
  input  logic         wr,
  input  logic         rd,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] int_sel,
  input  logic         int_lvl,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe,
  output logic [7:0]   rdata,
  output logic         irq_pend
);
  logic         hit;
  field_e       fld;
  logic [W-1:0] wd;
  logic         unused_wd;

  logic [W-1:0] dir_q, dir_d, out_q, out_d, pol_q, pol_d, sty_q, sty_d;
  logic [W-1:0] ien_q, ien_d, sts_q, sts_d, lat_q, lat_d;
  logic [W-1:0] s1_q, s2_q, s3_q;
  logic [W-1:0] edge_w, pulse_go, pulse_act;
  logic         rd_sts, wr_out;
  logic [W-1:0] rd_val;

  assign hit       = (idx[7:3] == BASE[7:3]);
  assign fld       = field_e'(idx[2:0]);
  assign wd        = wdata[W-1:0];
  assign unused_wd = ^wdata;
  assign rd_sts    = rd && hit && (fld == F_STS);
  assign wr_out    = wr && hit && (fld == F_OUT);

  // change detection on synchronized levels, inputs only, not the interrupt pin
  assign edge_w = (s2_q ^ s3_q) & dir_q & ~int_sel & {W{armed}};

  always_comb begin
    dir_d = dir_q;
    out_d = out_q;
    pol_d = pol_q;
    sty_d = sty_q;
    ien_d = ien_q;
    sts_d = (rd_sts ? '0 : sts_q) | edge_w;
    if (ext_clr) begin
      dir_d = DIR_RST;
      out_d = '0;
      pol_d = POL_RST;
      sty_d = '0;
      ien_d = '0;
      sts_d = '0;
    end else if (wr && hit) begin
      case (fld)
        F_DIR:   dir_d = wd;
        F_OUT:   out_d = wd;
        F_POL:   pol_d = wd;
        F_STY:   sty_d = wd;
        F_IEN:   ien_d = wd;
        default: ;
      endcase
    end
    lat_d = cap_now ? pin_i : lat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= DIR_RST;
      out_q <= '0;
      pol_q <= POL_RST;
      sty_q <= '0;
      ien_q <= '0;
      sts_q <= '0;
      lat_q <= '0;
      s1_q  <= '0;
      s2_q  <= '0;
      s3_q  <= '0;
    end else begin
      dir_q <= dir_d;
      out_q <= out_d;
      pol_q <= pol_d;
      sty_q <= sty_d;
      ien_q <= ien_d;
      sts_q <= sts_d;
      lat_q <= lat_d;
      s1_q  <= pin_i;
      s2_q  <= s1_q;
      s3_q  <= s2_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pulse_go[i] = wr_out && wdata[i] && sty_q[i];

    gpio_xint_pulse #(.LEN(LEN)) u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (ext_clr),
      .start  (pulse_go[i]),
      .active (pulse_act[i])
    );

    always_comb begin
      if (int_sel[i])     pin_o[i] = int_lvl;
      else if (sty_q[i])  pin_o[i] = pol_q[i] ^ pulse_act[i];
      else                pin_o[i] = out_q[i] ^ pol_q[i];
    end
    assign pin_oe[i] = int_sel[i] | ~dir_q[i];
  end

  always_comb begin
    case (fld)
      F_DIR:   rd_val = dir_q;
      F_OUT:   rd_val = out_q;
      F_POL:   rd_val = pol_q;
      F_STY:   rd_val = sty_q;
      F_IN:    rd_val = s2_q ^ pol_q;
      F_LAT:   rd_val = lat_q;
      F_STS:   rd_val = sts_q & ~int_sel;
      default: rd_val = ien_q;
    endcase
  end

  assign rdata    = hit ? 8'(rd_val) : 8'h00;
  assign irq_pend = |(sts_q & ien_q & ~int_sel);
endmodule

// File: rtl/gpio_xint_bank.sv
module gpio_xint_bank
  import gpio_xint_pkg::*;
#(
  parameter int              P1_W      = 8,
  parameter int              P2_W      = 7,
  parameter int              PULSE_LEN = 16,
  parameter logic [P1_W-1:0] P1_DIR_RST = 8'hFF,
  parameter logic [P2_W-1:0] P2_DIR_RST = 7'h7F,
  parameter logic [P1_W-1:0] P1_POL_RST = 8'hF0,
  parameter logic [P2_W-1:0] P2_POL_RST = 7'h70
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_rst_n,
  input  logic [7:0]      reg_idx,
  input  logic [7:0]      reg_wdata,
  input  logic            reg_wr,
  input  logic            reg_rd,
  output logic [7:0]      reg_rdata,
  input  logic [P1_W-1:0] p1_in,
  output logic [P1_W-1:0] p1_out,
  output logic [P1_W-1:0] p1_oe,
  input  logic [P2_W-1:0] p2_in,
  output logic [P2_W-1:0] p2_out,
  output logic [P2_W-1:0] p2_oe
);
  localparam logic [1:0] WARM_DONE = 2'd3;

  mode_t           mode_q, mode_d;
  logic [1:0]      warm_q, warm_d;
  logic            armed, pend, pend_q, int_start, int_pulse_act, int_lvl;
  logic [P1_W-1:0] sel1;
  logic [P2_W-1:0] sel2;
  logic [7:0]      rd1, rd2, rd_local;
  logic            pend1, pend2;

  assign mode_d = (reg_wr && reg_idx == IDX_MODE) ? mode_t'(reg_wdata) : mode_q;
  assign warm_d = (warm_q == WARM_DONE) ? warm_q : warm_q + 2'd1;
  assign armed  = (warm_q == WARM_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      warm_q <= '0;
      pend_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      warm_q <= warm_d;
      pend_q <= pend;
    end
  end

  always_comb begin
    sel1 = '0;
    sel2 = '0;
    sel1[P1_W-1] = mode_q.int_on && !mode_q.int_alt;
    sel2[P2_W-1] = mode_q.int_on &&  mode_q.int_alt;
  end

  assign pend      = pend1 | pend2;
  assign int_start = mode_q.int_pulse && pend && !pend_q;
  assign int_lvl   = mode_q.int_idle_hi ^ (mode_q.int_pulse ? int_pulse_act : pend);

  gpio_xint_pulse #(.LEN(PULSE_LEN)) u_int_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (1'b0),
    .start  (int_start),
    .active (int_pulse_act)
  );

  gpio_xint_port #(
    .W(P1_W), .BASE(IDX_P1), .DIR_RST(P1_DIR_RST), .POL_RST(P1_POL_RST), .LEN(PULSE_LEN)
  ) u_port1 (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_clr  (!ext_rst_n && mode_q.p1_xrst),
    .cap_now  ((warm_q == 2'd0) || (!ext_rst_n && mode_q.p1_xlat)),
    .armed    (armed),
    .idx      (reg_idx),
    .wdata    (reg_wdata),
    .wr       (reg_wr),
    .rd       (reg_rd),
    .pin_i    (p1_in),
    .int_sel  (sel1),
    .int_lvl  (int_lvl),
    .pin_o    (p1_out),
    .pin_oe   (p1_oe),
    .rdata    (rd1),
    .irq_pend (pend1)
  );

  gpio_xint_port #(
    .W(P2_W), .BASE(IDX_P2), .DIR_RST(P2_DIR_RST), .POL_RST(P2_POL_RST), .LEN(PULSE_LEN)
  ) u_port2 (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_clr  (!ext_rst_n && mode_q.p2_xrst),
    .cap_now  ((warm_q == 2'd0) || (!ext_rst_n && mode_q.p2_xlat)),
    .armed    (armed),
    .idx      (reg_idx),
    .wdata    (reg_wdata),
    .wr       (reg_wr),
    .rd       (reg_rd),
    .pin_i    (p2_in),
    .int_sel  (sel2),
    .int_lvl  (int_lvl),
    .pin_o    (p2_out),
    .pin_oe   (p2_oe),
    .rdata    (rd2),
    .irq_pend (pend2)
  );

  always_comb begin
    case (reg_idx)
      IDX_MODE:  rd_local = mode_q;
      IDX_ID_HI: rd_local = ID_HI_VAL;
      IDX_ID_LO: rd_local = ID_LO_VAL;
      default:   rd_local = 8'h00;
    endcase
  end

  assign reg_rdata = rd1 | rd2 | rd_local;
endmodule

// File: rtl/gpio_xint_chk.sv
module gpio_xint_chk #(
  parameter int P1_W = 8,
  parameter int P2_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ext_rst_n,
  input logic [7:0]      reg_idx,
  input logic [7:0]      reg_wdata,
  input logic            reg_wr,
  input logic [7:0]      reg_rdata,
  input logic [P1_W-1:0] p1_oe,
  input logic [P2_W-1:0] p2_oe,
  input logic [7:0]      mode
);
  // R1: a direction write shows on the output enables in the next cycle
  assert_dir_oe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == 8'h00 && ext_rst_n && !mode[7]) |=> (p1_oe == ~$past(reg_wdata[P1_W-1:0])));

  // R12: identification value
  assert_id_lo_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx == 8'h21) |-> (reg_rdata == 8'h13));

  // R11: external reset never alters the mode register
  assert_mode_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rst_n && !(reg_wr && reg_idx == 8'h10)) |=> $stable(mode));

  // R8: the interrupt pin is always driven
  assert_int_oe_p1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[7] && !mode[6]) |-> p1_oe[P1_W-1]);
  assert_int_oe_p2_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[7] && mode[6]) |-> p2_oe[P2_W-1]);

  // R10: the interrupt pin's status bit reads zero
  assert_sts_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[7] && !mode[6] && reg_idx == 8'h06) |-> !reg_rdata[P1_W-1]);
endmodule

bind gpio_xint_bank gpio_xint_chk #(.P1_W(P1_W), .P2_W(P2_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ext_rst_n (ext_rst_n),
  .reg_idx   (reg_idx),
  .reg_wdata (reg_wdata),
  .reg_wr    (reg_wr),
  .reg_rdata (reg_rdata),
  .p1_oe     (p1_oe),
  .p2_oe     (p2_oe),
  .mode      (mode_q)
);

// File: tb/gpio_xint_bank_tb.sv
`timescale 1ns/1ps
module gpio_xint_bank_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_rst_n = 1'b1;
  logic [7:0] reg_idx = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic [7:0] p1_in = 8'h5A;
  logic [7:0] p1_out, p1_oe;
  logic [6:0] p2_in = 7'h33;
  logic [6:0] p2_out, p2_oe;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  gpio_xint_bank dut_i (
    .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata),
    .p1_in(p1_in), .p1_out(p1_out), .p1_oe(p1_oe),
    .p2_in(p2_in), .p2_out(p2_out), .p2_oe(p2_oe)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0] m_dir[2], m_out[2], m_pol[2], m_sty[2], m_lat[2], m_sts[2], m_ien[2];
  logic [7:0] h1[2], h2[2], h3[2];
  logic [7:0] m_mode;
  int         warm;
  int         pc[2][8];
  int         ic;
  bit         pendq;
  bit         m_init = 1'b0;

  function automatic logic [7:0] mask(int p);
    return (p == 0) ? 8'hFF : 8'h7F;
  endfunction

  function automatic logic [7:0] pins(int p);
    return (p == 0) ? p1_in : {1'b0, p2_in};
  endfunction

  function automatic logic [7:0] isel(int p);
    if (!m_mode[7]) return 8'h00;
    if (p == 0) return m_mode[6] ? 8'h00 : 8'h80;
    return m_mode[6] ? 8'h40 : 8'h00;
  endfunction

  function automatic bit pend_now();
    return |((m_sts[0] & m_ien[0] & ~isel(0)) | (m_sts[1] & m_ien[1] & ~isel(1)));
  endfunction

  function automatic bit int_level();
    return m_mode[4] ^ (m_mode[5] ? (ic > 0) : pend_now());
  endfunction

  function automatic logic [7:0] exp_out(int p);
    logic [7:0] v = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (isel(p)[i])        v[i] = int_level();
      else if (m_sty[p][i])  v[i] = m_pol[p][i] ^ (pc[p][i] > 0);
      else                   v[i] = m_out[p][i] ^ m_pol[p][i];
    end
    return v & mask(p);
  endfunction

  function automatic logic [7:0] exp_oe(int p);
    return (isel(p) | ~m_dir[p]) & mask(p);
  endfunction

  function automatic logic [7:0] exp_rd(logic [7:0] idx);
    int p;
    if (idx < 8'h10) begin
      p = idx[3];
      case (idx[2:0])
        3'd0: return m_dir[p];
        3'd1: return m_out[p];
        3'd2: return m_pol[p];
        3'd3: return m_sty[p];
        3'd4: return (h2[p] ^ m_pol[p]) & mask(p);
        3'd5: return m_lat[p];
        3'd6: return m_sts[p] & ~isel(p);
        default: return m_ien[p];
      endcase
    end
    if (idx == 8'h10) return m_mode;
    if (idx == 8'h20) return 8'h60;
    if (idx == 8'h21) return 8'h13;
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin
        m_dir[p] = mask(p); m_pol[p] = (p == 0) ? 8'hF0 : 8'h70;
        m_out[p] = 0; m_sty[p] = 0; m_lat[p] = 0; m_sts[p] = 0; m_ien[p] = 0;
        h1[p] = 0; h2[p] = 0; h3[p] = 0;
        for (int i = 0; i < 8; i++) pc[p][i] = 0;
      end
      m_mode = 0; warm = 0; ic = 0; pendq = 0; m_init = 1'b1;
    end else begin
      logic [7:0] edg[2];
      logic [7:0] sel_now[2];
      bit         xclr[2], cap[2], hit[2], pnd;
      for (int p = 0; p < 2; p++) begin
        sel_now[p] = isel(p);
        edg[p]  = (h2[p] ^ h3[p]) & m_dir[p] & ~sel_now[p] & mask(p) & ((warm == 3) ? 8'hFF : 8'h00);
        xclr[p] = !ext_rst_n && m_mode[2 + p];
        cap[p]  = (warm == 0) || (!ext_rst_n && m_mode[p]);
        hit[p]  = (reg_idx[7:3] == p);
      end
      pnd = pend_now();
      if (m_mode[5] && pnd && !pendq) ic = 16;
      else if (ic > 0) ic--;
      pendq = pnd;
      for (int p = 0; p < 2; p++) begin
        for (int i = 0; i < 8; i++) begin
          if (xclr[p]) pc[p][i] = 0;
          else if (reg_wr && hit[p] && reg_idx[2:0] == 3'd1 && reg_wdata[i] && m_sty[p][i]) pc[p][i] = 16;
          else if (pc[p][i] > 0) pc[p][i]--;
        end
        if (xclr[p]) begin
          m_dir[p] = mask(p); m_pol[p] = (p == 0) ? 8'hF0 : 8'h70;
          m_out[p] = 0; m_sty[p] = 0; m_ien[p] = 0; m_sts[p] = 0;
        end else begin
          m_sts[p] = ((reg_rd && hit[p] && reg_idx[2:0] == 3'd6) ? 8'h00 : m_sts[p]) | edg[p];
          if (reg_wr && hit[p]) begin
            case (reg_idx[2:0])
              3'd0: m_dir[p] = reg_wdata & mask(p);
              3'd1: m_out[p] = reg_wdata & mask(p);
              3'd2: m_pol[p] = reg_wdata & mask(p);
              3'd3: m_sty[p] = reg_wdata & mask(p);
              3'd7: m_ien[p] = reg_wdata & mask(p);
              default: ;
            endcase
          end
        end
        if (cap[p]) m_lat[p] = pins(p);
        h3[p] = h2[p]; h2[p] = h1[p]; h1[p] = pins(p);
      end
      if (reg_wr && reg_idx == 8'h10) m_mode = reg_wdata;
      if (warm < 3) warm++;
    end
  end

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #3;
    if (rst_n && m_init && !done) begin
      check(cur_req, "p1_out", p1_out, exp_out(0));
      check(cur_req, "p1_oe", p1_oe, exp_oe(0));
      check(cur_req, "p2_out", {1'b0, p2_out}, exp_out(1));
      check(cur_req, "p2_oe", {1'b0, p2_oe}, exp_oe(1));
      check(cur_req, "rdata", reg_rdata, exp_rd(reg_idx));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(logic [7:0] idx, logic [7:0] d);
    @(negedge clk); reg_idx = idx; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_chk(logic [7:0] idx, logic [7:0] exp, string req, bit clr);
    @(negedge clk); reg_idx = idx; reg_rd = clr;
    #3 check(req, "read", reg_rdata, exp);
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic rd_clr(logic [7:0] idx);
    @(negedge clk); reg_idx = idx; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin_chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    #3 check(req, what, act, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    idle(5);

    cur_req = "R1";
    rd_chk(8'h00, 8'hFF, "R1", 0);
    @(negedge clk); pin_chk("R1", "p2_oe reset", {1'b0, p2_oe}, 8'h00);
    cur_req = "R2";
    rd_chk(8'h0A, 8'h70, "R2", 0);
    rd_chk(8'h02, 8'hF0, "R2", 0);
    cur_req = "R12";
    rd_chk(8'h20, 8'h60, "R12", 0);
    rd_chk(8'h21, 8'h13, "R12", 0);
    rd_chk(8'h17, 8'h00, "R12", 0);
    rd_chk(8'h30, 8'h00, "R12", 0);
    cur_req = "R6";
    rd_chk(8'h05, 8'h5A, "R6", 0);
    rd_chk(8'h0D, 8'h33, "R6", 0);

    cur_req = "R3";
    wr(8'h00, 8'h0F);
    wr(8'h01, 8'hA0);
    pin_chk("R3", "p1_out level", p1_out, 8'h50);
    check("R1", "p1_oe", p1_oe, 8'hF0);
    rd_chk(8'h01, 8'hA0, "R3", 0);

    cur_req = "R2";
    wr(8'h02, 8'h00);
    pin_chk("R2", "p1_out no invert", p1_out, 8'hA0);

    cur_req = "R5";
    @(negedge clk); p1_in = 8'h03;
    idle(4);
    rd_chk(8'h04, 8'h03, "R5", 0);
    cur_req = "R7";
    rd_chk(8'h06, 8'h09, "R7", 1);
    rd_chk(8'h06, 8'h00, "R7", 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); p1_in[0] = ~p1_in[0];
      idle(k);
      rd_clr(8'h06);
      idle(5);
    end
    rd_clr(8'h06);

    cur_req = "R4";
    wr(8'h03, 8'h40);
    wr(8'h01, 8'h40);
    pin_chk("R4", "pulse start", {7'b0, p1_out[6]}, 8'h01);
    idle(15);
    pin_chk("R4", "pulse last", {7'b0, p1_out[6]}, 8'h01);
    idle(1);
    pin_chk("R4", "pulse end", {7'b0, p1_out[6]}, 8'h00);

    cur_req = "R8";
    wr(8'h07, 8'h0F);
    wr(8'h10, 8'h80);
    @(negedge clk); p1_in[1] = ~p1_in[1];
    idle(5);
    pin_chk("R8", "int active", {7'b0, p1_out[7]}, 8'h01);
    rd_chk(8'h06, 8'h02, "R8", 1);
    pin_chk("R8", "int released", {7'b0, p1_out[7]}, 8'h00);
    wr(8'h10, 8'h90);
    pin_chk("R8", "int idle high", {7'b0, p1_out[7]}, 8'h01);

    cur_req = "R9";
    wr(8'h10, 8'hE0);
    begin
      int ones = 0;
      @(negedge clk); p1_in[0] = ~p1_in[0];
      for (int c = 0; c < 30; c++) begin @(negedge clk); #3 ones += p2_out[6]; end
      check("R9", "pulse width", 8'(ones), 8'd16);
      ones = 0;
      p1_in[0] = ~p1_in[0];
      for (int c = 0; c < 30; c++) begin @(negedge clk); #3 ones += p2_out[6]; end
      check("R9", "no refire", 8'(ones), 8'd0);
    end
    rd_clr(8'h06);
    @(negedge clk); p1_in[2] = ~p1_in[2];
    idle(24);

    cur_req = "R10";
    wr(8'h10, 8'h80);
    wr(8'h00, 8'h8F);
    rd_clr(8'h06);
    @(negedge clk); p1_in[7] = ~p1_in[7];
    idle(5);
    rd_chk(8'h06, 8'h00, "R10", 0);
    pin_chk("R10", "int pin oe", {7'b0, p1_oe[7]}, 8'h01);

    cur_req = "R11";
    wr(8'h08, 8'h70);
    wr(8'h10, 8'h85);
    @(negedge clk); p1_in = 8'hC3;
    idle(4);
    @(negedge clk); ext_rst_n = 1'b0;
    idle(2);
    ext_rst_n = 1'b1;
    idle(1);
    rd_chk(8'h00, 8'hFF, "R11", 0);
    rd_chk(8'h08, 8'h70, "R11", 0);
    rd_chk(8'h10, 8'h85, "R11", 0);
    cur_req = "R6";
    rd_chk(8'h05, 8'hC3, "R6", 0);
    rd_chk(8'h0D, 8'h33, "R6", 0);
    cur_req = "R11";
    wr(8'h10, 8'h0A);
    @(negedge clk); ext_rst_n = 1'b0;
    idle(2);
    ext_rst_n = 1'b1;
    idle(1);
    rd_chk(8'h08, 8'h7F, "R11", 0);
    rd_chk(8'h0A, 8'h70, "R11", 0);
    idle(3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL %s watchdog actual=running expected=finished", cur_req);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule